// File: doc/BRIEF.md
# Codec Register Access Controller

This block stands between a host register port and the frame engine of a serial audio codec link. It makes sure that only one codec register access is in flight at a time. It turns each accepted host access into exactly one command slot for the frame engine. For a read, it then watches the incoming status slots for the answer. A read that gets no matching answer before the second frame boundary after issue completes with all-ones data and raises a sticky error flag. The same happens, with no command sent, when the link clock is reported unhealthy. A write completes once the frame engine takes it into an outgoing frame.

The block also holds a local control/status word. Reading that word returns the semaphore and error flags, and the read sets the semaphore bit. Software polls the semaphore to learn whether a codec access is still pending. Every codec access clears the semaphore when it completes, except a read of the GPIO pin status register. That read is answered at once from a local shadow of the latest incoming slot 12 data and never reaches the link.

The host request, host response and command ports are valid/ready. A transfer happens on a clock edge where both valid and ready are high. Once valid is raised, it and the fields it carries stay unchanged until ready is seen. The host request port is ready only while nothing is pending. The status and GPIO inputs are single-cycle strobes with no back-pressure.

Top module: `codec_access_ctrl`

## Requirements
- R1: From the acceptance of any host request until its response is taken, `hreq_ready` is low, so a second codec access can never overlap the first.
- R2: A host read with `hreq_local`=1 returns the local word: bit 0 holds the semaphore as it was before the read, bit 1 holds the read-error flag, and all other bits are 0. The read then sets the semaphore.
- R3: The semaphore is cleared when a codec access completes. This covers a write, a read answered by the codec, a timed-out read and a read or write completed because the link clock is unhealthy. It does not cover a GPIO pin status read.
- R4: A codec read of address `GPIO_ADDR` (default 7'h54) is answered in the next cycle with the shadow value. It sends no command and leaves the semaphore unchanged. A write to that address goes across the link like any other write.
- R5: Every `gpio_valid` strobe loads `gpio_data` into the GPIO shadow.
- R6: Each codec access to the link produces exactly one command handshake, never repeated. While `cmd_valid` is high and not accepted, the command fields hold still.
- R7: A write completes with `hrsp_valid` in the cycle after its command handshake, with response data 0.
- R8: A read completes with `sts_data` when a `sts_valid` strobe carries an `sts_addr` equal to the requested address. This must happen before the second `frame_sync` after the command handshake. The error flag is left unchanged.
- R9: A read with no matching status strobe by the second `frame_sync` after its handshake completes with all-ones data and sets the error flag. A strobe with a different address counts as no response.
- R10: While `link_clk_ok` is low, an accepted codec access completes in the next cycle with no command. A read returns all-ones and sets the error flag. A write returns 0.
- R11: The error flag is sticky. It is cleared only by a local write with bit 1 of `hreq_wdata` set. A local write with bit 1 clear leaves it unchanged.
- R12: Once `hrsp_valid` is high, it and `hrsp_rdata` stay unchanged until `hrsp_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_clk_ok | input | 1 | High while the link bit clock is healthy |
| frame_sync | input | 1 | One-cycle pulse at each link frame boundary |
| hreq_valid | input | 1 | Host request valid |
| hreq_ready | output | 1 | Controller can take a host request |
| hreq_local | input | 1 | 1: local control/status word, 0: codec register |
| hreq_write | input | 1 | 1: write, 0: read |
| hreq_addr | input | AW | Codec register address |
| hreq_wdata | input | DW | Write data |
| hrsp_valid | output | 1 | Host response valid |
| hrsp_ready | input | 1 | Host takes the response |
| hrsp_rdata | output | DW | Response data |
| cmd_valid | output | 1 | Command slot request to the frame engine |
| cmd_ready | input | 1 | Frame engine placed the command into a frame |
| cmd_write | output | 1 | Command is a write |
| cmd_addr | output | AW | Command register address |
| cmd_wdata | output | DW | Command write data |
| sts_valid | input | 1 | Status address and data slots carry a register reply |
| sts_addr | input | AW | Register address of the reply |
| sts_data | input | DW | Register data of the reply |
| gpio_valid | input | 1 | Frame carried valid slot 12 data |
| gpio_data | input | DW | Slot 12 GPIO pin levels |

## Verification
Most faults in the sequencing state show at the host ports within one to two frames. A controller stuck busy leaves `hreq_ready` low, and the bench's response wait then runs out. One that leaves waiting too early returns all-ones where codec data was expected. One that repeats a command changes the command handshake count seen by the link model. A wrong semaphore or error flag stays hidden until the next local read, so the bench reads the local word right before and right after every access. A stale GPIO shadow shows on the first GPIO pin status read after the pin levels change.

// File: rtl/cac_pkg.sv
package cac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } cac_state_e;

  localparam int unsigned SEMA_BIT = 0;
  localparam int unsigned RERR_BIT = 1;
endpackage

// File: rtl/cac_gpio_shadow.sv
module cac_gpio_shadow #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/cac_frame_timer.sv
module cac_frame_timer #(
  parameter int WAIT_FRAMES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic frame_sync,
  output logic expired
);
  localparam int CW = $clog2(WAIT_FRAMES + 2);
  localparam logic [CW-1:0] LIMIT = CW'(WAIT_FRAMES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)                          cnt <= '0;
    else if (run && frame_sync && cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign expired = run && frame_sync && (cnt == LIMIT);
endmodule

// File: rtl/cac_status.sv
module cac_status (
  input  logic clk,
  input  logic rst_n,
  input  logic sema_set,
  input  logic sema_clr,
  input  logic rerr_set,
  input  logic rerr_clr,
  output logic sema,
  output logic rerr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sema <= 1'b0;
      rerr <= 1'b0;
    end else begin
      if (sema_clr)      sema <= 1'b0;
      else if (sema_set) sema <= 1'b1;
      if (rerr_set)      rerr <= 1'b1;
      else if (rerr_clr) rerr <= 1'b0;
    end
  end
endmodule

// File: rtl/cac_sequencer.sv
module cac_sequencer
  import cac_pkg::*;
#(
  parameter int             AW        = 7,
  parameter int             DW        = 16,
  parameter logic [AW-1:0]  GPIO_ADDR = 7'h54
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_clk_ok,
  input  logic          hreq_valid,
  output logic          hreq_ready,
  input  logic          hreq_local,
  input  logic          hreq_write,
  input  logic [AW-1:0] hreq_addr,
  input  logic [DW-1:0] hreq_wdata,
  output logic          hrsp_valid,
  input  logic          hrsp_ready,
  output logic [DW-1:0] hrsp_rdata,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic          cmd_write,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_wdata,
  input  logic          sts_valid,
  input  logic [AW-1:0] sts_addr,
  input  logic [DW-1:0] sts_data,
  input  logic [DW-1:0] shadow,
  input  logic          sema,
  input  logic          rerr,
  input  logic          expired,
  output logic          tmr_clr,
  output logic          tmr_run,
  output logic          sema_set,
  output logic          sema_clr,
  output logic          rerr_set,
  output logic          rerr_clr
);
  localparam logic [DW-1:0] ONES = '1;

  cac_state_e    st_q, st_d;
  logic          wr_q, wr_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic [DW-1:0] rsp_q, rsp_d;
  logic          accept;

  assign accept     = hreq_valid && (st_q == ST_IDLE);
  assign hreq_ready = (st_q == ST_IDLE);
  assign hrsp_valid = (st_q == ST_RESP);
  assign hrsp_rdata = rsp_q;
  assign cmd_valid  = (st_q == ST_ISSUE) && link_clk_ok;
  assign cmd_write  = wr_q;
  assign cmd_addr   = addr_q;
  assign cmd_wdata  = wdata_q;
  assign tmr_run    = (st_q == ST_WAIT);

  always_comb begin
    st_d     = st_q;
    wr_d     = wr_q;
    addr_d   = addr_q;
    wdata_d  = wdata_q;
    rsp_d    = rsp_q;
    tmr_clr  = 1'b0;
    sema_set = 1'b0;
    sema_clr = 1'b0;
    rerr_set = 1'b0;
    rerr_clr = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        st_d = ST_RESP;
        if (hreq_local) begin
          if (hreq_write) begin
            rerr_clr = hreq_wdata[RERR_BIT];
            rsp_d    = '0;
          end else begin
            rsp_d           = '0;
            rsp_d[SEMA_BIT] = sema;
            rsp_d[RERR_BIT] = rerr;
            sema_set        = 1'b1;
          end
        end else if (!hreq_write && hreq_addr == GPIO_ADDR) begin
          rsp_d = shadow;
        end else if (!link_clk_ok) begin
          rsp_d    = hreq_write ? '0 : ONES;
          rerr_set = !hreq_write;
          sema_clr = 1'b1;
        end else begin
          st_d    = ST_ISSUE;
          wr_d    = hreq_write;
          addr_d  = hreq_addr;
          wdata_d = hreq_wdata;
        end
      end
      ST_ISSUE: begin
        if (!link_clk_ok) begin
          st_d     = ST_RESP;
          rsp_d    = wr_q ? '0 : ONES;
          rerr_set = !wr_q;
          sema_clr = 1'b1;
        end else if (cmd_ready) begin
          if (wr_q) begin
            st_d     = ST_RESP;
            rsp_d    = '0;
            sema_clr = 1'b1;
          end else begin
            st_d    = ST_WAIT;
            tmr_clr = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (sts_valid && sts_addr == addr_q) begin
          st_d     = ST_RESP;
          rsp_d    = sts_data;
          sema_clr = 1'b1;
        end else if (expired || !link_clk_ok) begin
          st_d     = ST_RESP;
          rsp_d    = ONES;
          rerr_set = 1'b1;
          sema_clr = 1'b1;
        end
      end
      ST_RESP: if (hrsp_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rsp_q   <= '0;
    end else begin
      st_q    <= st_d;
      wr_q    <= wr_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      rsp_q   <= rsp_d;
    end
  end
endmodule

// File: rtl/codec_access_ctrl.sv
module codec_access_ctrl #(
  parameter int            AW          = 7,
  parameter int            DW          = 16,
  parameter int            WAIT_FRAMES = 1,
  parameter logic [AW-1:0] GPIO_ADDR   = 7'h54
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_clk_ok,
  input  logic          frame_sync,
  input  logic          hreq_valid,
  output logic          hreq_ready,
  input  logic          hreq_local,
  input  logic          hreq_write,
  input  logic [AW-1:0] hreq_addr,
  input  logic [DW-1:0] hreq_wdata,
  output logic          hrsp_valid,
  input  logic          hrsp_ready,
  output logic [DW-1:0] hrsp_rdata,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic          cmd_write,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_wdata,
  input  logic          sts_valid,
  input  logic [AW-1:0] sts_addr,
  input  logic [DW-1:0] sts_data,
  input  logic          gpio_valid,
  input  logic [DW-1:0] gpio_data
);
  logic [DW-1:0] shadow_w;
  logic          sema_w, rerr_w, expired_w, tmr_clr_w, tmr_run_w;
  logic          sema_set_w, sema_clr_w, rerr_set_w, rerr_clr_w;

  cac_gpio_shadow #(.DW(DW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(gpio_valid), .din(gpio_data), .q(shadow_w)
  );

  cac_frame_timer #(.WAIT_FRAMES(WAIT_FRAMES)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr_w), .run(tmr_run_w),
    .frame_sync(frame_sync), .expired(expired_w)
  );

  cac_status u_status (
    .clk(clk), .rst_n(rst_n),
    .sema_set(sema_set_w), .sema_clr(sema_clr_w),
    .rerr_set(rerr_set_w), .rerr_clr(rerr_clr_w),
    .sema(sema_w), .rerr(rerr_w)
  );

  cac_sequencer #(.AW(AW), .DW(DW), .GPIO_ADDR(GPIO_ADDR)) u_seq (
    .clk(clk), .rst_n(rst_n), .link_clk_ok(link_clk_ok),
    .hreq_valid(hreq_valid), .hreq_ready(hreq_ready), .hreq_local(hreq_local),
    .hreq_write(hreq_write), .hreq_addr(hreq_addr), .hreq_wdata(hreq_wdata),
    .hrsp_valid(hrsp_valid), .hrsp_ready(hrsp_ready), .hrsp_rdata(hrsp_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .sts_valid(sts_valid), .sts_addr(sts_addr), .sts_data(sts_data),
    .shadow(shadow_w), .sema(sema_w), .rerr(rerr_w), .expired(expired_w),
    .tmr_clr(tmr_clr_w), .tmr_run(tmr_run_w),
    .sema_set(sema_set_w), .sema_clr(sema_clr_w),
    .rerr_set(rerr_set_w), .rerr_clr(rerr_clr_w)
  );
endmodule

// File: rtl/cac_checker.sv
module cac_checker #(
  parameter int            AW        = 7,
  parameter int            DW        = 16,
  parameter logic [AW-1:0] GPIO_ADDR = 7'h54
) (
  input logic          clk,
  input logic          rst_n,
  input logic          link_clk_ok,
  input logic          hreq_valid,
  input logic          hreq_ready,
  input logic          hreq_local,
  input logic          hreq_write,
  input logic [AW-1:0] hreq_addr,
  input logic          hrsp_valid,
  input logic          hrsp_ready,
  input logic [DW-1:0] hrsp_rdata,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          cmd_write,
  input logic [AW-1:0] cmd_addr,
  input logic [DW-1:0] cmd_wdata,
  input logic          sema
);
  logic codec_acc;
  assign codec_acc = hreq_valid && hreq_ready && !hreq_local;

  assert_cmd_blocks_host_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !hreq_ready);

  assert_rsp_blocks_host_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hrsp_valid |-> !hreq_ready);

  assert_write_done_clears_sema_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_write) |=> (hrsp_valid && !sema));

  assert_gpio_read_local_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (codec_acc && !hreq_write && hreq_addr == GPIO_ADDR) |=> (hrsp_valid && $stable(sema)));

  assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=>
      ((cmd_valid || !link_clk_ok) && $stable(cmd_addr) && $stable(cmd_write) && $stable(cmd_wdata)));

  assert_bad_clock_immediate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (codec_acc && !link_clk_ok) |=> hrsp_valid);

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (hrsp_valid && !hrsp_ready) |=> (hrsp_valid && $stable(hrsp_rdata)));
endmodule

bind codec_access_ctrl cac_checker #(.AW(AW), .DW(DW), .GPIO_ADDR(GPIO_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .link_clk_ok(link_clk_ok),
  .hreq_valid(hreq_valid), .hreq_ready(hreq_ready), .hreq_local(hreq_local),
  .hreq_write(hreq_write), .hreq_addr(hreq_addr),
  .hrsp_valid(hrsp_valid), .hrsp_ready(hrsp_ready), .hrsp_rdata(hrsp_rdata),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
  .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .sema(sema_w)
);

// File: tb/tb_codec_access_ctrl.sv
module tb_codec_access_ctrl;
  localparam int AW = 7;
  localparam int DW = 16;
  localparam int FRAME = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, link_clk_ok, fsync;
  logic          hreq_valid, hreq_ready, hreq_local, hreq_write;
  logic [AW-1:0] hreq_addr;
  logic [DW-1:0] hreq_wdata;
  logic          hrsp_valid, hrsp_ready;
  logic [DW-1:0] hrsp_rdata;
  logic          cmd_valid, cmd_ready, cmd_write;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata;
  logic          sts_valid;
  logic [AW-1:0] sts_addr;
  logic [DW-1:0] sts_data;
  logic          gpio_valid;
  logic [DW-1:0] gpio_data;

  assign cmd_ready = fsync;

  codec_access_ctrl dut (
    .clk(clk), .rst_n(rst_n), .link_clk_ok(link_clk_ok), .frame_sync(fsync),
    .hreq_valid(hreq_valid), .hreq_ready(hreq_ready), .hreq_local(hreq_local),
    .hreq_write(hreq_write), .hreq_addr(hreq_addr), .hreq_wdata(hreq_wdata),
    .hrsp_valid(hrsp_valid), .hrsp_ready(hrsp_ready), .hrsp_rdata(hrsp_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .sts_valid(sts_valid), .sts_addr(sts_addr), .sts_data(sts_data),
    .gpio_valid(gpio_valid), .gpio_data(gpio_data)
  );

  int errors = 0;
  int checks = 0;
  int ncmd = 0;
  int cyc = 0;
  int countdown = 0;
  logic [1:0]    eng_mode = 2'd0;
  logic [DW-1:0] eng_val = '0;
  logic [DW-1:0] gpio_src = 16'h0A5C;
  logic [AW-1:0] rsp_addr = '0;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] val;
    logic [1:0]    mode;
    logic [DW-1:0] exp;
    logic [1:0]    ncmd;
    logic          sema;
    logic          rerr;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 7'h02, 16'h1234, 2'd0, 16'h0000, 2'd1, 1'b0, 1'b0},
    '{1'b0, 7'h02, 16'hBEEF, 2'd0, 16'hBEEF, 2'd1, 1'b0, 1'b0},
    '{1'b0, 7'h18, 16'h5555, 2'd1, 16'hFFFF, 2'd1, 1'b0, 1'b1},
    '{1'b0, 7'h18, 16'h6666, 2'd2, 16'hFFFF, 2'd1, 1'b0, 1'b1},
    '{1'b0, 7'h7C, 16'h4144, 2'd0, 16'h4144, 2'd1, 1'b0, 1'b0},
    '{1'b1, 7'h54, 16'h00F0, 2'd0, 16'h0000, 2'd1, 1'b0, 1'b0},
    '{1'b0, 7'h54, 16'h0000, 2'd0, 16'h0A5C, 2'd0, 1'b1, 1'b0},
    '{1'b0, 7'h26, 16'h000F, 2'd0, 16'h000F, 2'd1, 1'b0, 1'b0}
  };

  task automatic check(input logic ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Link model: frame boundary pulses, command accept on frame_sync, status replies
  initial begin
    fsync = 1'b0; sts_valid = 1'b0; sts_addr = '0; sts_data = '0;
    gpio_valid = 1'b0; gpio_data = '0;
    forever begin
      @(negedge clk);
      cyc++;
      fsync      = (cyc % FRAME == 0);
      gpio_valid = fsync;
      gpio_data  = gpio_src;
      sts_valid  = 1'b0;
      if (countdown > 0) begin
        countdown--;
        if (countdown == 0) begin
          sts_valid = 1'b1;
          sts_addr  = rsp_addr;
          sts_data  = eng_val;
        end
      end
      #1;
      if (cmd_valid && cmd_ready) begin
        ncmd++;
        if (!cmd_write && eng_mode != 2'd1) begin
          countdown = FRAME + 3;
          rsp_addr  = (eng_mode == 2'd2) ? (cmd_addr ^ 7'h01) : cmd_addr;
        end
      end
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic do_req(input logic loc, input logic wr, input logic [AW-1:0] a,
                        input logic [DW-1:0] d);
    @(negedge clk);
    hreq_valid = 1'b1; hreq_local = loc; hreq_write = wr; hreq_addr = a; hreq_wdata = d;
    #1;
    while (!hreq_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    hreq_valid = 1'b0;
  endtask

  task automatic get_rsp(output logic [DW-1:0] d);
    int wd = 0;
    d = 'x;
    while (!(hrsp_valid && hrsp_ready)) begin
      @(negedge clk); #1;
      wd++;
      if (wd > 200) begin
        check(1'b0, "response timeout", 16'h0, 16'h1);
        return;
      end
    end
    d = hrsp_rdata;
    @(negedge clk);
  endtask

  task automatic access(input logic loc, input logic wr, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output logic [DW-1:0] r);
    do_req(loc, wr, a, d);
    get_rsp(r);
  endtask

  initial begin
    logic [DW-1:0] r, held;
    int n0;
    rst_n = 1'b0; link_clk_ok = 1'b1; hrsp_ready = 1'b1;
    hreq_valid = 1'b0; hreq_local = 1'b0; hreq_write = 1'b0; hreq_addr = '0; hreq_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(hreq_ready && !hrsp_valid && !cmd_valid, "reset ports", {13'd0, hreq_ready, hrsp_valid, cmd_valid}, 16'h4);

    // R2: first local read after reset shows clear flags, second shows semaphore set
    access(1'b1, 1'b0, '0, '0, r);
    check(r == 16'h0000, "R2 first local read", r, 16'h0000);
    access(1'b1, 1'b0, '0, '0, r);
    check(r == 16'h0001, "R2 semaphore set by read", r, 16'h0001);

    // wait for at least one GPIO frame so the shadow holds gpio_src (R5)
    repeat (2 * FRAME) @(negedge clk);

    // Vector table: R3 R4 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      eng_mode = VEC[i].mode;
      eng_val  = VEC[i].val;
      access(1'b1, 1'b1, '0, 16'h0002, r);
      access(1'b1, 1'b0, '0, '0, r);
      check(r[1] == 1'b0, "R11 flag cleared before vector", r, {r[15:2], 1'b0, r[0]});
      n0 = ncmd;
      access(1'b0, VEC[i].wr, VEC[i].addr, VEC[i].val, r);
      check(r == VEC[i].exp, "R7/R8/R9/R4 vector data", r, VEC[i].exp);
      check((ncmd - n0) == int'(VEC[i].ncmd), "R6 command count", 16'(ncmd - n0), 16'(VEC[i].ncmd));
      access(1'b1, 1'b0, '0, '0, r);
      check(r[0] == VEC[i].sema, "R3 semaphore after access", {15'd0, r[0]}, {15'd0, VEC[i].sema});
      check(r[1] == VEC[i].rerr, "R9 error flag after access", {15'd0, r[1]}, {15'd0, VEC[i].rerr});
    end

    // R1: host port stays busy across a timed-out read
    eng_mode = 2'd1;
    do_req(1'b0, 1'b0, 7'h30, '0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); #1;
      if (k % 5 == 0) check(!hreq_ready, "R1 busy while read pending", {15'd0, hreq_ready}, 16'h0);
    end
    get_rsp(r);
    check(r == 16'hFFFF, "R9 timeout data", r, 16'hFFFF);

    // R11: local write with bit1 clear leaves flag, bit1 set clears it
    access(1'b1, 1'b1, '0, 16'h0001, r);
    access(1'b1, 1'b0, '0, '0, r);
    check(r[1] == 1'b1, "R11 flag sticky", r, {r[15:2], 1'b1, r[0]});
    access(1'b1, 1'b1, '0, 16'h0002, r);
    access(1'b1, 1'b0, '0, '0, r);
    check(r[1] == 1'b0, "R11 flag cleared by write", r, {r[15:2], 1'b0, r[0]});

    // R5: new pin levels appear in the shadow after a frame
    gpio_src = 16'h3C3C;
    repeat (2 * FRAME) @(negedge clk);
    access(1'b0, 1'b0, 7'h54, '0, r);
    check(r == 16'h3C3C, "R5 shadow refresh", r, 16'h3C3C);

    // R12: response held under back-pressure
    hrsp_ready = 1'b0;
    do_req(1'b0, 1'b0, 7'h54, '0);
    repeat (4) @(negedge clk);
    #1;
    held = hrsp_rdata;
    check(hrsp_valid && held == 16'h3C3C, "R12 response held", held, 16'h3C3C);
    hrsp_ready = 1'b1;
    get_rsp(r);
    check(r == 16'h3C3C, "R12 response data after release", r, 16'h3C3C);

    // R10: bad link clock, read and write complete without a command
    link_clk_ok = 1'b0;
    eng_mode = 2'd0;
    access(1'b1, 1'b1, '0, 16'h0002, r);
    n0 = ncmd;
    access(1'b0, 1'b0, 7'h02, '0, r);
    check(r == 16'hFFFF, "R10 read data", r, 16'hFFFF);
    access(1'b0, 1'b1, 7'h02, 16'hAAAA, r);
    check(r == 16'h0000, "R10 write data", r, 16'h0000);
    check(ncmd == n0, "R10 no command", 16'(ncmd - n0), 16'h0);
    access(1'b1, 1'b0, '0, '0, r);
    check(r[1] == 1'b1, "R10 error flag set", r, {r[15:2], 1'b1, r[0]});
    link_clk_ok = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule